// File: doc/BRIEF.md
# Processor Mode and Exception Entry Controller

This block keeps the status and mode state of a 32-bit processor core. It owns an 8-bit current status word (interrupt masks, instruction-set state and mode number), one saved status word and one link register for each of the five exception modes, and the program counter value that the fetch unit must jump to. Each cycle it accepts seven exception request lines, a return-from-exception strobe, a privileged status write and a branch-exchange request with its operand value.

When exceptions are requested, the controller picks one by fixed priority. It then carries out the entry sequence in a single clock:
- the target mode's link register takes the return address;
- the target mode's saved status takes the current status word;
- the mode field is forced to the target mode;
- the instruction-set bit drops back to the 32-bit state;
- the interrupt masks are raised;
- the program counter jumps to the exception vector.

A return strobe reverses this. It loads the program counter from the current mode's link register minus an offset that belongs to the exception that was taken, and it copies the saved status back.

All outputs are registered. An action requested in one cycle is visible on the outputs after the next rising clock edge.

Top module: `excp_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `status_o` is 0xD3 (bit 7 interrupt mask = 1, bit 6 fast-interrupt mask = 1, bit 5 instruction-set state = 0, bits [4:0] mode = supervisor 10011), `pc_o` is 0 and `taken_o` is 0.
- R2: On an accepted exception, the next `status_o[4:0]` is the target mode and `status_o[5]` is 0. The modes are: reset and software interrupt to supervisor 10011, undefined to 11011, both aborts to 10111, interrupt to 10010, fast interrupt to 10001. The next `pc_o` is the vector: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. `taken_o` has the single bit of the accepted request set. Request bit indexes are: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 interrupt, 6 fast interrupt.
- R3: Every accepted exception sets `status_o[7]`. `status_o[6]` is set on reset and fast-interrupt entries and keeps its value on all other entries.
- R4: On entry, the target mode's link register takes `ret_addr` and its saved status takes the status word from before the entry.
- R5: Among simultaneous requests, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt. An interrupt request is ignored while bit 7 is set, and a fast-interrupt request is ignored while bit 6 is set.
- R6: A branch-exchange sets `status_o[5]` to bit 0 of `bx_operand` and leaves the mode and mask bits unchanged. It loads `pc_o` with the operand with bit 0 cleared when going to the 16-bit state, and with bits [1:0] cleared when going to the 32-bit state.
- R7: A return strobe in an exception mode loads `pc_o` with that mode's link register minus an offset: 0 for reset, undefined and software interrupt; 4 for prefetch abort, interrupt and fast interrupt; 8 for data abort. It also restores `status_o` from that mode's saved status.
- R8: A return strobe in user (10000) or system (11111) mode loads `pc_o` with `ret_addr` and leaves `status_o` unchanged.
- R9: Within one cycle, an accepted exception takes precedence over a return, a return over a status write, and a status write over a branch-exchange. The lower-ranked requests in that cycle have no effect.
- R10: Each exception mode keeps its own link register and saved status. Entering a second mode does not disturb the first mode's saved values.
- R11: A status write (`psr_wr`) replaces all 8 status bits with `psr_wdata` in any mode except user. In user mode the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 7 | Exception request lines, one per kind (bit indexes in R2) |
| ret_addr | input | 32 | Return address stored on entry; new PC for a return in user or system mode |
| rtn_valid | input | 1 | Return-from-exception strobe |
| psr_wr | input | 1 | Status write request |
| psr_wdata | input | 8 | Status write value |
| bx_valid | input | 1 | Branch-exchange request |
| bx_operand | input | 32 | Branch-exchange operand register value |
| status_o | output | 8 | Current status word: [7] interrupt mask, [6] fast-interrupt mask, [5] instruction-set state, [4:0] mode |
| pc_o | output | 32 | Next program counter |
| taken_o | output | 7 | One-hot mark of the exception accepted in the previous cycle |

## Verification
The assertions assume that every written status value carries one of the seven legal mode numbers, and that request inputs change only between clock edges. They also assume a return is issued only after the exception mode's bank has been filled by an entry, so the offset and saved status it reads are meaningful. The stimulus only writes legal mode values and issues each return in an exception mode after an entry into that mode. It applies inputs on the falling edge and then compares the registered outputs against a reference model of the status, the banks and the program counter, which is kept in the bench itself.

// File: rtl/excp_pkg.sv
// Package excp_pkg
// Shared constants and lookup functions for the exception/mode controller.
// Assumes request index numbering: 0 reset, 1 undefined, 2 soft interrupt,
// 3 prefetch abort, 4 data abort, 5 interrupt, 6 fast interrupt.
package excp_pkg;
    localparam int NUM_EXC = 7;
    localparam int NBANK   = 5;
    localparam int BW      = $clog2(NBANK);

    localparam int EX_RST = 0;
    localparam int EX_UND = 1;
    localparam int EX_SWI = 2;
    localparam int EX_PAB = 3;
    localparam int EX_DAB = 4;
    localparam int EX_IRQ = 5;
    localparam int EX_FIQ = 6;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    // Status bit positions
    localparam int SB_I = 7;
    localparam int SB_F = 6;
    localparam int SB_T = 5;

    // Priority rank to request index, rank 0 highest
    function automatic int prio_at(input int rank);
        case (rank)
            0: return EX_RST;
            1: return EX_DAB;
            2: return EX_FIQ;
            3: return EX_IRQ;
            4: return EX_PAB;
            5: return EX_UND;
            default: return EX_SWI;
        endcase
    endfunction

    // Vector address of each exception kind
    function automatic logic [7:0] vec_of(input int k);
        case (k)
            EX_RST: return 8'h00;
            EX_UND: return 8'h04;
            EX_SWI: return 8'h08;
            EX_PAB: return 8'h0C;
            EX_DAB: return 8'h10;
            EX_IRQ: return 8'h18;
            default: return 8'h1C;
        endcase
    endfunction

    // Mode entered by each exception kind
    function automatic logic [4:0] mode_of(input int k);
        case (k)
            EX_RST, EX_SWI: return M_SVC;
            EX_UND:         return M_UND;
            EX_PAB, EX_DAB: return M_ABT;
            EX_IRQ:         return M_IRQ;
            default:        return M_FIQ;
        endcase
    endfunction

    // Return address offset subtracted from the link register
    function automatic logic [3:0] off_of(input int k);
        case (k)
            EX_PAB, EX_IRQ, EX_FIQ: return 4'd4;
            EX_DAB:                 return 4'd8;
            default:                return 4'd0;
        endcase
    endfunction

    // Bank slot of a mode; bit BW is the valid flag
    function automatic logic [BW:0] bank_of(input logic [4:0] m);
        case (m)
            M_FIQ:   return {1'b1, BW'(0)};
            M_IRQ:   return {1'b1, BW'(1)};
            M_SVC:   return {1'b1, BW'(2)};
            M_ABT:   return {1'b1, BW'(3)};
            M_UND:   return {1'b1, BW'(4)};
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/excp_arb.sv
// Module excp_arb
// Masks interrupt and fast-interrupt requests with the current status bits
// and grants the single highest-priority remaining request.
// Purely combinational; assumes the mask inputs are the registered status.
module excp_arb
    import excp_pkg::*;
(
    input  logic [NUM_EXC-1:0] req,
    input  logic               imask,
    input  logic               fmask,
    output logic [NUM_EXC-1:0] grant
);
    logic [NUM_EXC-1:0] eff;

    // Drop requests that the current masks block
    always_comb begin
        eff         = req;
        eff[EX_IRQ] = req[EX_IRQ] & ~imask;
        eff[EX_FIQ] = req[EX_FIQ] & ~fmask;
    end

    // Walk the fixed priority order and keep the first live request
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int r = 0; r < NUM_EXC; r++) begin
            if (!found && eff[prio_at(r)]) begin
                grant[prio_at(r)] = 1'b1;
                found             = 1'b1;
            end
        end
    end
endmodule

// File: rtl/excp_bank.sv
// Module excp_bank
// Per-mode storage of link register, saved status and return offset.
// One write port used on exception entry, one combinational read port
// addressed by the current mode's slot. Assumes widx < NB when we is high.
module excp_bank
    import excp_pkg::*;
#(
    parameter int AW = 32,
    parameter int NB = NBANK,
    parameter int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] wlr,
    input  logic [7:0]    wsr,
    input  logic [3:0]    woff,
    input  logic [IW-1:0] ridx,
    output logic [AW-1:0] rlr,
    output logic [7:0]    rsr,
    output logic [3:0]    roff
);
    logic [AW-1:0] lr_q  [NB];
    logic [7:0]    sr_q  [NB];
    logic [3:0]    off_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_slot
        // Capture the entry values into this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lr_q[b]  <= '0;
                sr_q[b]  <= '0;
                off_q[b] <= '0;
            end else if (we && (widx == IW'(b))) begin
                lr_q[b]  <= wlr;
                sr_q[b]  <= wsr;
                off_q[b] <= woff;
            end
        end
    end

    // Read the slot of the current mode
    always_comb begin
        rlr  = lr_q[ridx];
        rsr  = sr_q[ridx];
        roff = off_q[ridx];
    end
endmodule

// File: rtl/excp_mode_ctrl.sv
// Module excp_mode_ctrl
// Status/mode controller: exception entry, return, status write and
// branch-exchange, resolved in that precedence within one cycle.
// Assumes written status values hold legal mode numbers.
module excp_mode_ctrl
    import excp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic [AW-1:0]      ret_addr,
    input  logic               rtn_valid,
    input  logic               psr_wr,
    input  logic [7:0]         psr_wdata,
    input  logic               bx_valid,
    input  logic [AW-1:0]      bx_operand,
    output logic [7:0]         status_o,
    output logic [AW-1:0]      pc_o,
    output logic [NUM_EXC-1:0] taken_o
);
    localparam logic [7:0] ST_RESET = {1'b1, 1'b1, 1'b0, M_SVC};

    logic [7:0]         st_q, st_n;
    logic [AW-1:0]      pc_q, pc_n;
    logic [NUM_EXC-1:0] tk_q, grant;
    logic               bw_en;
    logic [BW-1:0]      bw_idx;
    logic [BW:0]        wslot, rslot;
    logic [AW-1:0]      rd_lr;
    logic [7:0]         rd_sr;
    logic [3:0]         rd_off;
    logic [7:0]         en_sr;
    logic [3:0]         en_off;
    logic [4:0]         en_mode;
    logic [7:0]         en_vec;
    logic               en_fset;

    excp_arb u_arb (
        .req   (exc_req),
        .imask (st_q[SB_I]),
        .fmask (st_q[SB_F]),
        .grant (grant)
    );

    excp_bank #(.AW(AW), .NB(NBANK), .IW(BW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bw_en),
        .widx  (bw_idx),
        .wlr   (ret_addr),
        .wsr   (en_sr),
        .woff  (en_off),
        .ridx  (rslot[BW-1:0]),
        .rlr   (rd_lr),
        .rsr   (rd_sr),
        .roff  (rd_off)
    );

    // Decode the granted exception into mode, vector, offset and F-set
    always_comb begin
        en_mode = M_SVC;
        en_vec  = '0;
        en_off  = '0;
        en_fset = 1'b0;
        for (int k = 0; k < NUM_EXC; k++) begin
            if (grant[k]) begin
                en_mode = mode_of(k);
                en_vec  = vec_of(k);
                en_off  = off_of(k);
                en_fset = (k == EX_RST) || (k == EX_FIQ);
            end
        end
    end

    assign wslot  = bank_of(en_mode);
    assign rslot  = bank_of(st_q[4:0]);
    assign bw_en  = |grant;
    assign bw_idx = wslot[BW-1:0];
    assign en_sr  = st_q;

    // Select the next status and program counter by precedence
    always_comb begin
        st_n = st_q;
        pc_n = pc_q;
        if (|grant) begin
            st_n[4:0]  = en_mode;
            st_n[SB_T] = 1'b0;
            st_n[SB_I] = 1'b1;
            st_n[SB_F] = st_q[SB_F] | en_fset;
            pc_n       = AW'(en_vec);
        end else if (rtn_valid) begin
            if (rslot[BW]) begin
                pc_n = rd_lr - AW'(rd_off);
                st_n = rd_sr;
            end else begin
                pc_n = ret_addr;
            end
        end else if (psr_wr) begin
            if (st_q[4:0] != M_USR) st_n = psr_wdata;
        end else if (bx_valid) begin
            st_n[SB_T] = bx_operand[0];
            pc_n       = bx_operand[0] ? {bx_operand[AW-1:1], 1'b0}
                                       : {bx_operand[AW-1:2], 2'b00};
        end
    end

    // Register status, program counter and taken marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
            pc_q <= '0;
            tk_q <= '0;
        end else begin
            st_q <= st_n;
            pc_q <= pc_n;
            tk_q <= grant;
        end
    end

    assign status_o = st_q;
    assign pc_o     = pc_q;
    assign taken_o  = tk_q;
endmodule

// File: rtl/excp_mode_ctrl_chk.sv
// Module excp_mode_ctrl_chk
// Temporal checks on the controller's ports; bound into every instance.
module excp_mode_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [6:0]    exc_req,
    input logic [AW-1:0] ret_addr,
    input logic          rtn_valid,
    input logic          psr_wr,
    input logic          bx_valid,
    input logic [AW-1:0] bx_operand,
    input logic [7:0]    status_o,
    input logic [AW-1:0] pc_o,
    input logic [6:0]    taken_o
);
    // R5: never more than one exception accepted at a time
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken_o));

    // R2: entry leaves the 32-bit state and a word-aligned low vector
    a_r2_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        (|taken_o) |-> (!status_o[5] && pc_o[1:0] == 2'b00 && pc_o < AW'(32)));

    // R3: interrupt mask set after any entry
    a_r3_imask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|taken_o) |-> status_o[7]);

    // R5: a lone interrupt request under mask is not taken
    a_r5_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req == 7'b0100000 && status_o[7]) |=> (taken_o == 7'b0));

    // R6: branch-exchange sets state from operand bit 0, mode and masks kept
    a_r6_bx_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_valid && !rtn_valid && !psr_wr && exc_req == 7'b0)
        |=> (status_o[5] == $past(bx_operand[0]) && $stable(status_o[4:0])
             && $stable(status_o[7:6])));

    // R8: return in user or system mode takes ret_addr, status unchanged
    a_r8_plain_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rtn_valid && exc_req == 7'b0 &&
         (status_o[4:0] == 5'b10000 || status_o[4:0] == 5'b11111))
        |=> ($stable(status_o) && pc_o == $past(ret_addr)));
endmodule

bind excp_mode_ctrl excp_mode_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_req    (exc_req),
    .ret_addr   (ret_addr),
    .rtn_valid  (rtn_valid),
    .psr_wr     (psr_wr),
    .bx_valid   (bx_valid),
    .bx_operand (bx_operand),
    .status_o   (status_o),
    .pc_o       (pc_o),
    .taken_o    (taken_o)
);

// File: tb/excp_mode_ctrl_tb_top.sv
// Scoreboard bench: the driver applies one request per cycle and queues the
// reference model's prediction; the monitor pops and compares after the edge.
module excp_mode_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  exc_req;
    logic [31:0] ret_addr;
    logic        rtn_valid;
    logic        psr_wr;
    logic [7:0]  psr_wdata;
    logic        bx_valid;
    logic [31:0] bx_operand;
    logic [7:0]  status_o;
    logic [31:0] pc_o;
    logic [6:0]  taken_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [7:0]  st;
        logic [31:0] pc;
        logic [6:0]  tk;
        string       tag;
    } exp_t;
    exp_t q[$];

    // Reference model state
    logic [7:0]  m_st;
    logic [31:0] m_pc;
    logic [31:0] m_lr  [5];
    logic [7:0]  m_sr  [5];
    logic [31:0] m_off [5];

    always #2 clk = ~clk;

    excp_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_addr(ret_addr),
        .rtn_valid(rtn_valid), .psr_wr(psr_wr), .psr_wdata(psr_wdata),
        .bx_valid(bx_valid), .bx_operand(bx_operand), .status_o(status_o),
        .pc_o(pc_o), .taken_o(taken_o)
    );

    function automatic int slot_m(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    // One request cycle: drive inputs, advance the model, queue the prediction
    task automatic step(input logic [6:0] ex, input logic rt, input logic wr,
                        input logic [7:0] wd, input logic bx,
                        input logic [31:0] op, input logic [31:0] ra,
                        input string tag);
        int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
        logic [4:0]  tmode [7] = '{5'b10011, 5'b11011, 5'b10011, 5'b10111,
                                   5'b10111, 5'b10010, 5'b10001};
        logic [31:0] tvec  [7] = '{32'h00, 32'h04, 32'h08, 32'h0C,
                                   32'h10, 32'h18, 32'h1C};
        logic [31:0] toff  [7] = '{0, 0, 0, 4, 8, 4, 4};
        logic [6:0]  live;
        int          win;
        int          s;
        exp_t        e;
        @(negedge clk);
        exc_req = ex; rtn_valid = rt; psr_wr = wr; psr_wdata = wd;
        bx_valid = bx; bx_operand = op; ret_addr = ra;
        live = ex;
        if (m_st[7]) live[5] = 1'b0;
        if (m_st[6]) live[6] = 1'b0;
        win = -1;
        for (int r = 6; r >= 0; r--) if (live[ord[r]]) win = ord[r];
        e.tk = '0;
        if (win >= 0) begin
            e.tk[win] = 1'b1;
            s = slot_m(tmode[win]);
            m_lr[s] = ra; m_sr[s] = m_st; m_off[s] = toff[win];
            m_st = {1'b1, (m_st[6] | (win == 0) | (win == 6)), 1'b0, tmode[win]};
            m_pc = tvec[win];
        end else if (rt) begin
            s = slot_m(m_st[4:0]);
            if (s >= 0) begin
                m_pc = m_lr[s] - m_off[s];
                m_st = m_sr[s];
            end else begin
                m_pc = ra;
            end
        end else if (wr) begin
            if (m_st[4:0] != 5'b10000) m_st = wd;
        end else if (bx) begin
            m_st[5] = op[0];
            m_pc = op[0] ? {op[31:1], 1'b0} : {op[31:2], 2'b00};
        end
        e.st = m_st; e.pc = m_pc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exc_req = '0; rtn_valid = 0; psr_wr = 0; bx_valid = 0;
        end
    endtask

    // Monitor: compare each registered result just after the capturing edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (status_o !== e.st || pc_o !== e.pc || taken_o !== e.tk) begin
                bad++;
                $display("FAIL %s: status=%h pc=%h taken=%b expected status=%h pc=%h taken=%b",
                         e.tag, status_o, pc_o, taken_o, e.st, e.pc, e.tk);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exc_req = '0; rtn_valid = 0; psr_wr = 0; psr_wdata = '0;
        bx_valid = 0; bx_operand = '0; ret_addr = '0;
        rst_n = 0;
        m_st = 8'hD3; m_pc = '0;
        for (int i = 0; i < 5; i++) begin
            m_lr[i] = '0; m_sr[i] = '0; m_off[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        total++;
        if (status_o !== 8'hD3 || pc_o !== 32'h0 || taken_o !== 7'h0) begin
            bad++;
            $display("FAIL R1: status=%h pc=%h taken=%b expected status=d3 pc=0 taken=0",
                     status_o, pc_o, taken_o);
        end
        // R11: privileged write to user mode, then user-mode write ignored
        step(7'h00, 0, 1, 8'h10, 0, 32'h0, 32'h0, "R11 priv write");
        step(7'h00, 0, 1, 8'hD3, 0, 32'h0, 32'h0, "R11 user write ignored");
        // R6: branch-exchange both ways
        step(7'h00, 0, 0, 8'h0, 1, 32'h0000_1003, 32'h0, "R6 to 16-bit");
        step(7'h00, 0, 0, 8'h0, 1, 32'h0000_2006, 32'h0, "R6 to 32-bit");
        // R8: return in user mode
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h300, "R8 user return");
        // R2 R3 R4: interrupt entry from user
        step(7'h20, 0, 0, 8'h0, 0, 32'h0, 32'h404, "R2 R3 irq entry");
        // R5: masked interrupt ignored
        step(7'h20, 0, 0, 8'h0, 0, 32'h0, 32'h999, "R5 masked irq");
        // R5: fast interrupt beats prefetch abort and undefined
        step(7'h4A, 0, 0, 8'h0, 0, 32'h0, 32'h500, "R5 fiq wins");
        // R7 R10: nested returns restore each bank
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R7 fiq return");
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R10 irq bank kept");
        // R9 R5: reset wins over everything, incl. return and bx
        step(7'h7F, 1, 1, 8'h10, 1, 32'h1, 32'h600, "R9 reset wins");
        // Open masks in supervisor
        step(7'h00, 0, 1, 8'h13, 0, 32'h0, 32'h0, "R11 open masks");
        step(7'h70, 0, 0, 8'h0, 0, 32'h0, 32'h800, "R5 dabort wins");
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R7 dabort return");
        step(7'h0E, 0, 0, 8'h0, 0, 32'h0, 32'h900, "R5 pabort wins");
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R7 pabort return");
        step(7'h06, 0, 0, 8'h0, 0, 32'h0, 32'hA00, "R5 undef wins");
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R7 undef return");
        step(7'h04, 0, 0, 8'h0, 0, 32'h0, 32'hB00, "R2 swi entry");
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R7 swi return");
        // R9: return beats bx in supervisor
        step(7'h00, 1, 0, 8'h0, 1, 32'h1235, 32'h0, "R9 return over bx");
        // R9: write beats bx
        step(7'h00, 0, 1, 8'h1F, 1, 32'h4441, 32'h0, "R9 write over bx");
        // R8: return in system mode
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'hC40, "R8 system return");
        // R3: fast interrupt from open masks sets both
        step(7'h40, 0, 0, 8'h0, 0, 32'h0, 32'hD00, "R3 fiq sets F");
        // R4: return shows the saved system status and link value
        step(7'h00, 1, 0, 8'h0, 0, 32'h0, 32'h0, "R4 saved values");
        idle_n(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule